// File: doc/BRIEF.md
# Fetch-Stage Loop Buffer

This block sits between an instruction fetch stage and its memory port. It keeps a small, contiguous window of the most recently fetched instructions, described by a base address and a count of valid entries. Every fetch request is compared with that window. If the requested address lies inside it, the instruction comes from the local store and the memory port stays idle. A loop whose body fits in the window is therefore read from memory once and then replayed from the buffer.

A request that misses goes to memory. The memory port is an ideal zero-wait read: the returned word is valid in the same cycle as the address. The word that comes back is also written into the store. If the missed address directly follows the window, the window grows by one entry. Once the window is full, it slides forward and drops its oldest entry. Any other miss, such as a taken branch to a far target, discards the window and starts a new one at that address. Branch resolution is outside this block. A redirect reaches it only as a discontinuity in the requested address.

Addresses count instructions, not bytes, and all address arithmetic wraps modulo 2^AW. Each instruction is presented on the output one cycle after it is requested.

Top module: `loopBuffer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, instValid is 0 and winCount is 0. memReq is 0 whenever fetchReq is 0.
- R2: A request is a hit when (fetchAddr − winBase) mod 2^AW < winCount. On a hit, memReq is 0 in that cycle. In the next cycle instFromBuf is 1 and instData equals the word that memory returned for that address when it was filled.
- R3: A request that is not a hit raises memReq with memAddr equal to fetchAddr in the same cycle. In the next cycle instFromBuf is 0 and instData equals the memData of the request cycle.
- R4: instValid in a cycle equals fetchReq in the cycle before it, and instAddr then equals the requested address.
- R5: A miss at address winBase+winCount while winCount < DEPTH increments winCount and leaves winBase unchanged.
- R6: A miss at address winBase+winCount while winCount = DEPTH increments winBase and keeps winCount at DEPTH, so the oldest entry is dropped.
- R7: A miss at any other address restarts the window: winBase becomes the requested address and winCount becomes 1.
- R8: A hit, or a cycle without a request, leaves winBase and winCount unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fetchReq | input | 1 | Fetch request valid this cycle |
| fetchAddr | input | AW | Instruction address requested |
| memReq | output | 1 | Memory read strobe, raised on a miss |
| memAddr | output | AW | Address sent to memory |
| memData | input | DW | Instruction word returned by memory in the same cycle |
| instValid | output | 1 | Delivered instruction valid |
| instAddr | output | AW | Address of the delivered instruction |
| instData | output | DW | Delivered instruction word |
| instFromBuf | output | 1 | Delivered word came from the local store |
| winBase | output | AW | Oldest address held in the window |
| winCount | output | clog2(DEPTH+1) | Number of valid entries in the window |

## Verification
A wrong base or count changes the result of the next hit test, so it shows at memReq in the same cycle as the next request. If a branch target is mis-classified, memReq has the wrong value immediately and instFromBuf has the wrong value one cycle later. A wrong slot index or a missed store write does not change the hit decision. It shows only when that address is requested again, because instData then differs from the memory word for that address. The bench's memory returns a distinct word for every address, so this error is visible on the first replay.

// File: rtl/loopBufPkg.sv
package loopBufPkg;

  typedef enum logic [1:0] {
    FILL_NONE,
    FILL_APPEND,
    FILL_SLIDE,
    FILL_RESTART
  } fillKind_t;

  typedef struct packed {
    logic issue;
    logic hit;
    logic fill;
  } lbStrobes_t;

endpackage

// File: rtl/lbCtrl.sv
module lbCtrl
  import loopBufPkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fetchReq,
  input  logic [AW-1:0] fetchAddr,
  output lbStrobes_t    strobes,
  output logic          memReq,
  output logic [AW-1:0] winBase,
  output logic [CW-1:0] winCount
);

  logic [AW-1:0] baseQ;
  logic [CW-1:0] countQ;
  logic [AW-1:0] offset;
  logic          inWin;
  logic          nextInLine;
  logic          full;
  fillKind_t     fillKind;

  // distance of the request from the oldest held address, modulo 2^AW
  assign offset     = fetchAddr - baseQ;
  assign inWin      = offset < AW'(countQ);
  assign nextInLine = offset == AW'(countQ);
  assign full       = countQ == CW'(DEPTH);

  always_comb begin
    fillKind = FILL_NONE;
    if (fetchReq && !inWin) begin
      if (!nextInLine)  fillKind = FILL_RESTART;
      else if (full)    fillKind = FILL_SLIDE;
      else              fillKind = FILL_APPEND;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      countQ <= '0;
    end else begin
      unique case (fillKind)
        FILL_APPEND:  countQ <= countQ + CW'(1);
        FILL_SLIDE:   baseQ  <= baseQ + AW'(1);
        FILL_RESTART: begin
          baseQ  <= fetchAddr;
          countQ <= CW'(1);
        end
        default: ;
      endcase
    end
  end

  assign strobes.issue = fetchReq;
  assign strobes.hit   = fetchReq && inWin;
  assign strobes.fill  = fillKind != FILL_NONE;

  assign memReq   = fetchReq && !inWin;
  assign winBase  = baseQ;
  assign winCount = countQ;

endmodule

// File: rtl/lbData.sv
module lbData
  import loopBufPkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  lbStrobes_t    strobes,
  input  logic [AW-1:0] fetchAddr,
  input  logic [DW-1:0] memData,
  output logic          instValid,
  output logic [AW-1:0] instAddr,
  output logic [DW-1:0] instData,
  output logic          instFromBuf
);

  // The window never spans more than DEPTH consecutive addresses, so
  // address modulo DEPTH names a unique slot for every held entry.
  logic [DW-1:0] slots [DEPTH];
  logic [IW-1:0] slotIdx;
  logic [DW-1:0] rdWord;

  assign slotIdx = fetchAddr[IW-1:0];
  assign rdWord  = slots[slotIdx];

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (strobes.fill && slotIdx == IW'(g)) slots[g] <= memData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instValid   <= 1'b0;
      instAddr    <= '0;
      instData    <= '0;
      instFromBuf <= 1'b0;
    end else begin
      instValid   <= strobes.issue;
      instFromBuf <= strobes.hit;
      if (strobes.issue) begin
        instAddr <= fetchAddr;
        instData <= strobes.hit ? rdWord : memData;
      end
    end
  end

endmodule

// File: rtl/loopBuffer.sv
module loopBuffer
  import loopBufPkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         fetchReq,
  input  logic [AW-1:0]                fetchAddr,
  output logic                         memReq,
  output logic [AW-1:0]                memAddr,
  input  logic [DW-1:0]                memData,
  output logic                         instValid,
  output logic [AW-1:0]                instAddr,
  output logic [DW-1:0]                instData,
  output logic                         instFromBuf,
  output logic [AW-1:0]                winBase,
  output logic [$clog2(DEPTH+1)-1:0]   winCount
);

  lbStrobes_t strobes;

  lbCtrl #(.AW(AW), .DEPTH(DEPTH)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .fetchReq (fetchReq),
    .fetchAddr(fetchAddr),
    .strobes  (strobes),
    .memReq   (memReq),
    .winBase  (winBase),
    .winCount (winCount)
  );

  lbData #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .fetchAddr  (fetchAddr),
    .memData    (memData),
    .instValid  (instValid),
    .instAddr   (instAddr),
    .instData   (instData),
    .instFromBuf(instFromBuf)
  );

  assign memAddr = fetchAddr;

endmodule

// File: rtl/lbChecker.sv
module lbChecker #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          fetchReq,
  input logic [AW-1:0] fetchAddr,
  input logic          memReq,
  input logic [AW-1:0] memAddr,
  input logic [DW-1:0] memData,
  input logic          instValid,
  input logic [AW-1:0] instAddr,
  input logic          instFromBuf,
  input logic [DW-1:0] instData,
  input logic [AW-1:0] winBase,
  input logic [CW-1:0] winCount
);

  logic inWin;
  logic nextInLine;
  assign inWin      = (fetchAddr - winBase) < AW'(winCount);
  assign nextInLine = fetchAddr == winBase + AW'(winCount);

  assert_idle_no_mem_R1: assert property (@(posedge clk) disable iff (!rstN)
    !fetchReq |-> !memReq);

  assert_hit_no_mem_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && inWin) |-> !memReq);

  assert_hit_from_buf_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && inWin) |=> instFromBuf);

  assert_miss_mem_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !inWin) |-> (memReq && memAddr == fetchAddr));

  assert_miss_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !inWin) |=> (!instFromBuf && instData == $past(memData)));

  assert_issue_R4: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |=> (instValid && instAddr == $past(fetchAddr)));

  assert_no_issue_R4: assert property (@(posedge clk) disable iff (!rstN)
    !fetchReq |=> !instValid);

  assert_append_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !inWin && nextInLine && winCount < CW'(DEPTH))
    |=> (winCount == $past(winCount) + CW'(1) && $stable(winBase)));

  assert_slide_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !inWin && nextInLine && winCount == CW'(DEPTH))
    |=> (winBase == $past(winBase) + AW'(1) && winCount == CW'(DEPTH)));

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    winCount <= CW'(DEPTH));

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !inWin && !nextInLine)
    |=> (winBase == $past(fetchAddr) && winCount == CW'(1)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchReq || inWin) |=> ($stable(winBase) && $stable(winCount)));

endmodule

bind loopBuffer lbChecker #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) chk (
  .clk        (clk),
  .rstN       (rstN),
  .fetchReq   (fetchReq),
  .fetchAddr  (fetchAddr),
  .memReq     (memReq),
  .memAddr    (memAddr),
  .memData    (memData),
  .instValid  (instValid),
  .instAddr   (instAddr),
  .instFromBuf(instFromBuf),
  .instData   (instData),
  .winBase    (winBase),
  .winCount   (winCount)
);

// File: tb/loopBuffer_test.sv
`timescale 1ns/1ps
module loopBuffer_test;

  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          fetchReq = 1'b0;
  logic [AW-1:0] fetchAddr = '0;
  logic          memReq;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData;
  logic          instValid;
  logic [AW-1:0] instAddr;
  logic [DW-1:0] instData;
  logic          instFromBuf;
  logic [AW-1:0] winBase;
  logic [CW-1:0] winCount;

  int checks = 0;
  int failures = 0;

  logic [AW-1:0] mBase = '0;
  logic [CW-1:0] mCount = '0;

  always #10 clk = ~clk;

  loopBuffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .instValid(instValid), .instAddr(instAddr), .instData(instData),
    .instFromBuf(instFromBuf), .winBase(winBase), .winCount(winCount)
  );

  function automatic logic [DW-1:0] memFn(input logic [AW-1:0] a);
    return (DW'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  assign memData = memFn(memAddr);

  task automatic checkEq(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one request (or idle) starting at a falling edge, ends at the next falling edge
  task automatic step(input logic req, input logic [AW-1:0] a);
    logic expHit;
    logic [DW-1:0] expData;
    string winReq;
    fetchReq  = req;
    fetchAddr = a;
    #2;
    expHit = req && ((a - mBase) < AW'(mCount));
    if (!req) checkEq("R1", "memReq idle", memReq, 0);
    else if (expHit) checkEq("R2", "memReq on hit", memReq, 0);
    else begin
      checkEq("R3", "memReq on miss", memReq, 1);
      checkEq("R3", "memAddr", memAddr, a);
    end
    expData = memFn(a);
    winReq = "R8";
    if (req && !expHit) begin
      if (a == mBase + AW'(mCount)) begin
        if (mCount < CW'(DEPTH)) begin mCount++; winReq = "R5"; end
        else begin mBase++; winReq = "R6"; end
      end else begin
        mBase = a; mCount = CW'(1); winReq = "R7";
      end
    end
    @(negedge clk);
    checkEq("R4", "instValid", instValid, req);
    if (req) begin
      checkEq("R4", "instAddr", instAddr, a);
      checkEq(expHit ? "R2" : "R3", "instFromBuf", instFromBuf, expHit);
      checkEq(expHit ? "R2" : "R3", "instData", instData, expData);
    end
    checkEq(winReq, "winBase", winBase, mBase);
    checkEq(winReq, "winCount", winCount, mCount);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int unused;
    unused = $urandom(32'd4711);
    // R1: reset state
    repeat (3) @(negedge clk);
    checkEq("R1", "instValid in reset", instValid, 0);
    checkEq("R1", "winCount in reset", winCount, 0);
    checkEq("R1", "memReq in reset", memReq, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1", "instValid after reset", instValid, 0);
    checkEq("R1", "winCount after reset", winCount, 0);

    // directed: fill from 0 upward (R5), then slide once full (R6)
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, AW'(i));
    // loop back over the held window: all hits (R2, R8)
    for (int i = 2; i < DEPTH + 2; i++) step(1'b1, AW'(i));
    // below the window after slide: miss and restart (R7)
    step(1'b1, AW'(1));
    // idle cycle (R4, R8)
    step(1'b0, AW'(0));
    // far branch target restarts (R7), then a loop wrapping the address space
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < 5; i++) step(1'b1, AW'(16'hFFFE + i));
    // jump to the address just past the window appends rather than restarts (R5)
    step(1'b1, AW'(16'h0003));
    step(1'b1, AW'(16'hFFFE));

    // random loops and jumps
    for (int it = 0; it < 150; it++) begin
      logic [AW-1:0] start;
      int len, reps;
      start = AW'($urandom);
      if ($urandom % 3 == 0) start = mBase + AW'($urandom % (DEPTH + 2));
      len  = 1 + int'($urandom % (DEPTH + 3));
      reps = 1 + int'($urandom % 3);
      for (int r = 0; r < reps; r++)
        for (int i = 0; i < len; i++) begin
          if ($urandom % 8 == 0) step(1'b0, AW'($urandom));
          step(1'b1, start + AW'(i));
        end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule